// File: doc/BRIEF.md
# Byte-Wide Double-Buffered DAC Code Loader

This block assembles a 12-bit converter code from an 8-bit bus and holds it in two stages: a staging register that collects bytes, and a DAC register that drives the converter. Separate active-low selects address the high and the low byte. An active-low load input makes a byte write also update the DAC register in the same operation. With both selects inactive, the load input copies the staging register into the DAC register. Writes are qualified by an active-low write strobe that is synchronised to the system clock. Exactly one action happens for each falling edge of the synchronised strobe.

A mode input picks one of two jobs for the control input. With the mode input high, the control input picks where the bytes land in the 12-bit word, left- or right-justified. With the mode input low, the output code is forced to all zeros or all ones. The DAC register keeps its contents during the force. A full update takes three writes: the high byte, the low byte, then a load-only transfer. Fewer writes are possible by folding the load into a byte write.

Top module: `byte_dac_loader`

## Requirements
- R1: Synchronous active-high reset clears the staging register and the DAC register, so `code_out` reads 0 after reset while `mode_fmt` is high.
- R2: A strobe with `sel_hi_n`=1, `sel_lo_n`=0 and `xfer_n`=1 writes the low byte into the staging register only, and `code_out` does not change.
- R3: A strobe with `sel_hi_n`=1, `sel_lo_n`=0 and `xfer_n`=0 writes the low byte and loads the DAC register with the staging value including that new byte.
- R4: A strobe with `sel_hi_n`=0 and `sel_lo_n`=1 writes the high byte. With `xfer_n`=1 only the staging register changes. With `xfer_n`=0 the DAC register is also loaded with the merged value.
- R5: A strobe with both selects high and `xfer_n`=0 copies the staging register into the DAC register.
- R6: No transfer occurs while the strobe stays high. A strobe also transfers nothing when both selects are low, or when both selects are high with `xfer_n`=1.
- R7: With `mode_fmt`=0, `code_out` is forced to 12'h000 when `mode_ctl`=0 and to 12'hFFF when `mode_ctl`=1. When `mode_fmt` returns to 1, `code_out` shows the unchanged DAC register again.
- R8: Right justification (`mode_fmt`=1, `mode_ctl`=1): the low byte fills bits 7..0, and bits 3..0 of the high byte fill bits 11..8. Bits 7..4 of the high byte are ignored.
- R9: Left justification (`mode_fmt`=1, `mode_ctl`=0): the high byte fills bits 11..4, and bits 7..4 of the low byte fill bits 3..0. Bits 3..0 of the low byte are ignored.
- R10: The action takes place on the falling edge of the synchronised strobe. Its effect appears on `code_out` while the strobe is still held low, and only one action is taken per edge.
- R11: While `mode_fmt` is low, byte writes use the justification that was last selected with `mode_fmt` high. After reset that justification is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low, asynchronous to clk |
| sel_hi_n | input | 1 | High-byte select, active low |
| sel_lo_n | input | 1 | Low-byte select, active low |
| xfer_n | input | 1 | DAC register load, active low |
| mode_fmt | input | 1 | 1: mode_ctl selects justification; 0: mode_ctl forces the output |
| mode_ctl | input | 1 | Justification (0 left, 1 right) or forced level (0 zeros, 1 ones) |
| bus_d | input | 8 | Byte data bus |
| code_out | output | 12 | Registered effective converter code |

## Verification
Several rules are checked by assertions on every cycle. One is the single-cycle action pulse per strobe edge. Another is that the DAC register holds its value when no action occurs. The assertions also check that a combined write-and-load leaves the DAC register equal to the new staging value, and that the forced output levels are correct. Finally, they check that the justification latch holds during a force. Only the bench scenarios can show byte placement for whole sequences of codes in both justifications, and that bits outside the selected field are ignored. They also show that the DAC value survives a force and that the update arrives while the strobe is still low.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  // Byte placement inside the 12-bit code.
  typedef enum logic {
    JUST_LEFT  = 1'b0,
    JUST_RIGHT = 1'b1
  } just_e;

  // One decoded action, valid for a single clock cycle.
  typedef struct packed {
    logic put_lo;   // low byte into staging register
    logic put_hi;   // high byte into staging register
    logic xfer;     // staging (after merge) into DAC register
  } dl_cmd_t;
endpackage

// File: rtl/dacld_strobe_sync.sv
module dacld_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 1'b1;
        else     chain_q <= strobe_n;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], strobe_n};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= chain_q[STAGES-1];
  end

  assign fall = last_q & ~chain_q[STAGES-1];

  // An edge yields a single-cycle pulse.
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/dacld_decode.sv
module dacld_decode
  import dacld_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ev,
  input  logic    sel_hi_n,
  input  logic    sel_lo_n,
  input  logic    xfer_n,
  output dl_cmd_t cmd
);
  always_comb begin
    cmd = '0;
    if (ev) begin
      unique case ({sel_hi_n, sel_lo_n})
        2'b10: begin cmd.put_lo = 1'b1; cmd.xfer = ~xfer_n; end
        2'b01: begin cmd.put_hi = 1'b1; cmd.xfer = ~xfer_n; end
        2'b11: cmd.xfer = ~xfer_n;
        default: cmd = '0;  // both selects active: nothing
      endcase
    end
  end

  // No action without a strobe edge.
  assert_idle_no_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    !ev |-> (cmd == '0));
  assert_one_byte_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.put_lo, cmd.put_hi}));
endmodule

// File: rtl/dacld_stage_reg.sv
module dacld_stage_reg
  import dacld_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dl_cmd_t           cmd,
  input  just_e             just,
  input  logic [BUS_W-1:0]  bus_d,
  output logic [CODE_W-1:0] stage_q,
  output logic [CODE_W-1:0] stage_nxt
);
  // Width of the partial field taken from the second byte.
  localparam int PART_W = CODE_W - BUS_W;

  always_comb begin
    stage_nxt = stage_q;
    if (cmd.put_lo) begin
      if (just == JUST_RIGHT) stage_nxt[BUS_W-1:0]  = bus_d;
      else                    stage_nxt[PART_W-1:0] = bus_d[BUS_W-1:BUS_W-PART_W];
    end
    if (cmd.put_hi) begin
      if (just == JUST_RIGHT) stage_nxt[CODE_W-1:BUS_W]  = bus_d[PART_W-1:0];
      else                    stage_nxt[CODE_W-1:PART_W] = bus_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_nxt;
  end

  assert_lo_right_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd.put_lo && just == JUST_RIGHT) |=> stage_q[BUS_W-1:0] == $past(bus_d));
  assert_hi_left_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd.put_hi && just == JUST_LEFT) |=> stage_q[CODE_W-1:PART_W] == $past(bus_d));
  assert_stage_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(cmd.put_lo || cmd.put_hi) |=> $stable(stage_q));
endmodule

// File: rtl/dacld_out_stage.sv
module dacld_out_stage #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_fmt,
  input  logic              mode_ctl,
  input  logic [CODE_W-1:0] dac_q,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst)            code_q <= '0;
    else if (!mode_fmt) code_q <= {CODE_W{mode_ctl}};
    else                code_q <= dac_q;
  end

  assert_force_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!mode_fmt && !mode_ctl) |=> code_q == '0);
  assert_force_one_R7: assert property (@(posedge clk) disable iff (rst)
    (!mode_fmt && mode_ctl) |=> code_q == '1);
  assert_pass_R7: assert property (@(posedge clk) disable iff (rst)
    mode_fmt |=> code_q == $past(dac_q));
endmodule

// File: rtl/byte_dac_loader.sv
module byte_dac_loader
  import dacld_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              sel_hi_n,
  input  logic              sel_lo_n,
  input  logic              xfer_n,
  input  logic              mode_fmt,
  input  logic              mode_ctl,
  input  logic [BUS_W-1:0]  bus_d,
  output logic [CODE_W-1:0] code_out
);
  logic              ev;
  dl_cmd_t           cmd;
  just_e             just_q;
  just_e             just_eff;
  logic [CODE_W-1:0] stage_q;
  logic [CODE_W-1:0] stage_nxt;
  logic [CODE_W-1:0] dac_q;

  dacld_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .strobe_n(wr_n), .fall(ev)
  );

  dacld_decode u_dec (
    .clk(clk), .rst(rst), .ev(ev),
    .sel_hi_n(sel_hi_n), .sel_lo_n(sel_lo_n), .xfer_n(xfer_n), .cmd(cmd)
  );

  // Justification is remembered while the control input serves as force level.
  always_ff @(posedge clk) begin
    if (rst)           just_q <= JUST_LEFT;
    else if (mode_fmt) just_q <= just_e'(mode_ctl);
  end

  assign just_eff = mode_fmt ? just_e'(mode_ctl) : just_q;

  dacld_stage_reg #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_stage (
    .clk(clk), .rst(rst), .cmd(cmd), .just(just_eff), .bus_d(bus_d),
    .stage_q(stage_q), .stage_nxt(stage_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)           dac_q <= '0;
    else if (cmd.xfer) dac_q <= stage_nxt;
  end

  dacld_out_stage #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst(rst), .mode_fmt(mode_fmt), .mode_ctl(mode_ctl),
    .dac_q(dac_q), .code_q(code_out)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dac_q == '0) && (stage_q == '0));
  assert_xfer_merge_R3: assert property (@(posedge clk) disable iff (rst)
    cmd.xfer |=> dac_q == stage_q);
  assert_dac_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ev |=> $stable(dac_q));
  assert_just_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !mode_fmt |=> $stable(just_q));
endmodule

// File: tb/byte_dac_loader_tb.sv
module byte_dac_loader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_n = 1'b1, sel_hi_n = 1'b1, sel_lo_n = 1'b1, xfer_n = 1'b1;
  logic        mode_fmt = 1'b1, mode_ctl = 1'b0;
  logic [7:0]  bus_d = 8'h00;
  logic [11:0] code_out;

  int vectors = 0;
  int fails   = 0;
  int stage_m = 0;   // model of staging register
  int dac_m   = 0;   // model of DAC register
  bit right_m = 0;   // model of remembered justification

  always #5 clk = ~clk;

  byte_dac_loader u_dut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .sel_hi_n(sel_hi_n), .sel_lo_n(sel_lo_n),
    .xfer_n(xfer_n), .mode_fmt(mode_fmt), .mode_ctl(mode_ctl),
    .bus_d(bus_d), .code_out(code_out)
  );

  task automatic chk(input string req, input int exp);
    vectors++;
    if (int'(code_out) != exp) begin
      fails++;
      $display("FAIL %s: code_out=%03h expected=%03h", req, code_out, exp[11:0]);
    end
  endtask

  function automatic int place(input bit right, input bit hi, input int d, input int cur);
    if (right && !hi) return (cur & 'hF00) | (d & 'hFF);
    if (right &&  hi) return (cur & 'h0FF) | ((d & 'hF) * 256);
    if (!right && hi) return (cur & 'h00F) | ((d & 'hFF) * 16);
    return (cur & 'hFF0) | ((d & 'hFF) / 16);
  endfunction

  task automatic set_mode(input logic f, input logic c);
    @(negedge clk);
    mode_fmt = f; mode_ctl = c;
    if (f) right_m = c;
    repeat (2) @(negedge clk);
  endtask

  // One strobe. mid_req non-empty: check the output while the strobe is still low.
  task automatic strobe(input logic hn, input logic ln, input logic xn,
                        input logic [7:0] d, input string mid_req);
    bit r;
    @(negedge clk);
    sel_hi_n = hn; sel_lo_n = ln; xfer_n = xn; bus_d = d; wr_n = 1'b0;
    r = mode_fmt ? mode_ctl : right_m;
    if ({hn, ln} == 2'b10) stage_m = place(r, 0, d, stage_m);
    if ({hn, ln} == 2'b01) stage_m = place(r, 1, d, stage_m);
    if (!xn && {hn, ln} != 2'b00) dac_m = stage_m;
    repeat (5) @(negedge clk);
    if (mid_req.len() > 0) chk(mid_req, mode_fmt ? dac_m : (mode_ctl ? 'hFFF : 0));
    @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    sel_hi_n = 1'b1; sel_lo_n = 1'b1; xfer_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", 0);

    // Right-justified sweep: three-write sequence, with checks between writes.
    set_mode(1'b1, 1'b1);
    for (int i = 0; i < 48; i++) begin
      int v;
      int old;
      v = (i * 2731 + 'h5A3) & 'hFFF;
      old = dac_m;
      strobe(1'b0, 1'b1, 1'b1, 8'((v >> 8) | ((i & 15) << 4)), "");
      chk("R4", old);
      strobe(1'b1, 1'b0, 1'b1, 8'(v & 'hFF), "");
      chk("R2", old);
      strobe(1'b1, 1'b1, 1'b0, 8'h00, "");
      chk("R5", v);
      chk("R8", dac_m);
    end

    // Left-justified sweep: high byte, then low byte with load folded in.
    set_mode(1'b1, 1'b0);
    for (int i = 0; i < 48; i++) begin
      int v;
      v = (i * 1553 + 'h2C7) & 'hFFF;
      strobe(1'b0, 1'b1, 1'b1, 8'(v >> 4), "");
      strobe(1'b1, 1'b0, 1'b0, 8'(((v & 15) << 4) | (i & 15)), "");
      chk("R3", v);
      chk("R9", dac_m);
    end

    // High-byte write with load, right-justified, upper nibble ignored.
    set_mode(1'b1, 1'b1);
    strobe(1'b0, 1'b1, 1'b0, 8'hF6, "R10");
    chk("R4", dac_m);
    chk("R8", (dac_m & 'hF00) == 'h600 ? dac_m : -1);

    // No-transfer cases: stage differs from DAC first.
    strobe(1'b1, 1'b0, 1'b1, 8'h3C, "");
    @(negedge clk);
    sel_hi_n = 1'b1; sel_lo_n = 1'b1; xfer_n = 1'b0; bus_d = 8'h99;
    repeat (8) @(negedge clk);
    chk("R6", dac_m);
    xfer_n = 1'b1;
    strobe(1'b0, 1'b0, 1'b0, 8'hAB, "");
    chk("R6", dac_m);
    strobe(1'b1, 1'b1, 1'b1, 8'h00, "");
    chk("R6", dac_m);
    strobe(1'b1, 1'b1, 1'b0, 8'h00, "R10");
    chk("R5", stage_m);

    // Force levels and return to the kept DAC value.
    set_mode(1'b0, 1'b0);
    chk("R7", 0);
    set_mode(1'b0, 1'b1);
    chk("R7", 'hFFF);
    set_mode(1'b1, 1'b1);
    chk("R7", dac_m);

    // Remembered justification during a force: right, then left.
    set_mode(1'b1, 1'b1);
    set_mode(1'b0, 1'b0);
    strobe(1'b1, 1'b0, 1'b0, 8'h5E, "R7");
    set_mode(1'b1, 1'b1);
    chk("R11", dac_m);
    chk("R11", ((dac_m & 'hFF) == 'h5E) ? dac_m : -1);
    set_mode(1'b1, 1'b0);
    set_mode(1'b0, 1'b1);
    strobe(1'b1, 1'b0, 1'b0, 8'hC7, "R7");
    set_mode(1'b1, 1'b0);
    chk("R11", dac_m);
    chk("R11", ((dac_m & 'hF) == 'hC) ? dac_m : -1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule